// File: doc/BRIEF.md
# Successive Interference Cancellation Stage

This block is one link in a chain that strips users out of a direct-sequence spread-spectrum baseband stream, one user per link. It takes signed in-phase and quadrature samples together with that user's two PN chip streams and a marker for the first chip of each symbol, all already aligned to the user's estimated path delay by the PN generator feeding it. It despreads both branches (non-coherent reception), takes a hard sign decision and an amplitude estimate for each symbol, and then rebuilds the user's I and Q contribution from them. That contribution is subtracted, sample by sample, from a copy of the input that has waited in a fixed-length delay line.

The delay line holds one symbol plus the largest expected delay spread. A symbol's decision is therefore always ready before its first delayed sample reaches the subtractor. The output has the same sample format as the input, so the next link (wired to the next-strongest user) can take it directly. Each link runs continuously on its own valid strobe, which makes the chain indifferent to whether users are synchronous.

Two small state machines drive the block. The correlator machine has the states CS_WAIT (no symbol open) and CS_ACC (accumulating). CS_WAIT goes to CS_ACC on an accepted sample carrying the symbol marker. CS_ACC goes back to CS_WAIT on the accepted sample that completes a symbol. A marker seen in CS_ACC restarts the sum. The output machine has the states ST_FILL (delay line not yet full) and ST_RUN. ST_FILL goes to ST_RUN on the accepted sample that fills the delay line. ST_RUN is held until reset.

Top module: `sic_stage`

## Requirements
- R1: While reset is asserted and directly after it, out_valid and dec_valid are low and out_i and out_q are zero.
- R2: A symbol opens on an accepted sample (in_valid high) with sym_start high and spans SPS accepted samples. Over it, C is the sum of x_i·p_i + x_q·p_q, where PN bit 1 means +1 and 0 means −1. dec_bit is 1 when C ≥ 0 and 0 otherwise. dec_valid is high for exactly one cycle, the cycle after the last sample of the symbol is accepted. Samples accepted while no symbol is open add nothing.
- R3: dec_amp is |C| shifted right by log2(SPS)+1, that is, |C| divided by 2·SPS and rounded down.
- R4: With D = SPS + SPREAD (SPREAD at most SPS−1), out_valid stays low until D samples have been accepted. The k-th output is built from the k-th accepted input and appears in the cycle after input k+D is accepted, so the first output follows the (D+1)-th accepted input.
- R5: Each output equals the delayed sample minus a replica r. r is +dec_amp when the decision bit equals that sample's PN bit on the same branch, and −dec_amp otherwise. The decision used is the one of the symbol the delayed sample belongs to, even when that symbol's first sample leaves the delay line in the same cycle the next decision is formed.
- R6: Samples accepted before the first completed decision reaches the delay line output leave the block unchanged.
- R7: The subtraction saturates to the range −2^(W−1) … 2^(W−1)−1 and does not wrap.
- R8: A cycle with in_valid low accepts nothing, holds the delay line, and gives out_valid low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample strobe |
| in_i | input | SAMPLE_W | In-phase sample, signed |
| in_q | input | SAMPLE_W | Quadrature sample, signed |
| pn_i | input | 1 | In-phase PN chip of this user (1 = +1) |
| pn_q | input | 1 | Quadrature PN chip of this user (1 = +1) |
| sym_start | input | 1 | First chip of a symbol of this user |
| out_valid | output | 1 | Output sample strobe |
| out_i | output | SAMPLE_W | In-phase sample with this user removed |
| out_q | output | SAMPLE_W | Quadrature sample with this user removed |
| dec_valid | output | 1 | Symbol decision strobe |
| dec_bit | output | 1 | Hard decision (1 = +1) |
| dec_amp | output | SAMPLE_W | Amplitude estimate, unsigned |

## Verification
Two functions can land in the same cycle: forming the decision of symbol k+1, and moving symbol k's first delayed sample to the subtractor, where symbol k's decision must be adopted. The default spread of SPS−1 samples makes these two fall on the same accepted sample at every symbol boundary. Every stream therefore provokes the collision, both with idle gaps in the strobe and without them. The bench judges it by comparing every output sample against a replica that the bench model builds from the decision of the symbol that sample belongs to. Taking the next symbol's decision at the boundary shows up as a wrong output on the first sample of each symbol.

// File: rtl/sic_pkg.sv
package sic_pkg;

    // Correlator: waiting for a symbol marker, or summing a symbol
    typedef enum logic {
        CS_WAIT = 1'b0,
        CS_ACC  = 1'b1
    } corr_state_e;

    // Output side: delay line filling, or producing cancelled samples
    typedef enum logic {
        ST_FILL = 1'b0,
        ST_RUN  = 1'b1
    } out_state_e;

endpackage

// File: rtl/sic_delay_line.sv
module sic_delay_line #(
    parameter int W     = 12,
    parameter int DEPTH = 15
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                shift_en,
    input  logic signed [W-1:0] din_i,
    input  logic signed [W-1:0] din_q,
    input  logic                din_pi,
    input  logic                din_pq,
    input  logic                din_st,
    output logic signed [W-1:0] head_i,
    output logic signed [W-1:0] head_q,
    output logic                head_pi,
    output logic                head_pq,
    output logic                head_st
);
    localparam int EW = 2*W + 3;

    logic [EW-1:0] tap [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) tap[k] <= '0;
        end else if (shift_en) begin
            tap[0] <= {din_st, din_pq, din_pi, din_q, din_i};
            for (int k = 1; k < DEPTH; k++) tap[k] <= tap[k-1];
        end
    end

    assign {head_st, head_pq, head_pi, head_q, head_i} = tap[DEPTH-1];

    AST_HEAD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(tap[DEPTH-1])); // R8

endmodule

// File: rtl/sic_correlator.sv
module sic_correlator
    import sic_pkg::*;
#(
    parameter int W   = 12,
    parameter int SPS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic signed [W-1:0] x_i,
    input  logic signed [W-1:0] x_q,
    input  logic                pn_i,
    input  logic                pn_q,
    input  logic                sym_start,
    output logic                dec_valid,
    output logic                dec_bit,
    output logic [W-1:0]        dec_amp
);
    localparam int L  = $clog2(SPS);
    localparam int AW = W + L + 2;
    localparam int CW = $clog2(SPS + 1);

    corr_state_e         cs, cs_nxt;
    logic signed [AW-1:0] acc, acc_nxt, prod_i, prod_q;
    logic [AW-1:0]        mag;
    logic [CW-1:0]        cnt, cnt_nxt;
    logic                 take, last;

    // despread arithmetic for the sample at the input
    always_comb begin
        prod_i  = pn_i ? AW'(x_i) : -AW'(x_i);
        prod_q  = pn_q ? AW'(x_q) : -AW'(x_q);
        take    = in_valid && (sym_start || (cs == CS_ACC));
        acc_nxt = (sym_start ? AW'(0) : acc) + prod_i + prod_q;
        cnt_nxt = (sym_start ? CW'(0) : cnt) + CW'(1);
        last    = take && (cnt_nxt == CW'(SPS));
        mag     = acc_nxt[AW-1] ? AW'(-acc_nxt) : AW'(acc_nxt);
    end

    always_comb begin
        cs_nxt = cs;
        unique case (cs)
            CS_WAIT: if (in_valid && sym_start) cs_nxt = last ? CS_WAIT : CS_ACC;
            CS_ACC:  if (in_valid && last)      cs_nxt = CS_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cs <= CS_WAIT;
        else        cs <= cs_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc       <= '0;
            cnt       <= '0;
            dec_valid <= 1'b0;
            dec_bit   <= 1'b1;
            dec_amp   <= '0;
        end else begin
            dec_valid <= 1'b0;
            if (take) begin
                acc <= acc_nxt;
                cnt <= cnt_nxt;
            end
            if (last) begin
                dec_valid <= 1'b1;
                dec_bit   <= !acc_nxt[AW-1];
                dec_amp   <= W'(mag >> (L + 1));
            end
        end
    end

    AST_DEC_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> $past(in_valid)); // R2

    AST_AMP_HALF_SCALE: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> !(dec_amp[W-1] && (|dec_amp[W-2:0]))); // R3

    if (SPS > 1) begin : g_spaced
        AST_DEC_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
            dec_valid |=> !dec_valid); // R2
    end

endmodule

// File: rtl/sic_canceller.sv
module sic_canceller
    import sic_pkg::*;
#(
    parameter int W     = 12,
    parameter int DEPTH = 15
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic signed [W-1:0] head_i,
    input  logic signed [W-1:0] head_q,
    input  logic                head_pi,
    input  logic                head_pq,
    input  logic                head_st,
    input  logic                dec_bit,
    input  logic [W-1:0]        dec_amp,
    output logic                out_valid,
    output logic signed [W-1:0] out_i,
    output logic signed [W-1:0] out_q
);
    localparam int FW = $clog2(DEPTH + 1);

    out_state_e     st, st_nxt;
    logic [FW-1:0]  fill;
    logic           act_bit, use_bit;
    logic [W-1:0]   act_amp, use_amp;

    function automatic logic signed [W-1:0] cancel_one(
        input logic signed [W-1:0] x,
        input logic                chip,
        input logic                b,
        input logic [W-1:0]        a
    );
        logic signed [W+1:0] r, d;
        logic signed [W+1:0] hi, lo;
        hi = $signed({3'b000, {(W-1){1'b1}}});
        lo = $signed({3'b111, {(W-1){1'b0}}});
        r  = (b == chip) ? $signed({2'b00, a}) : -$signed({2'b00, a});
        d  = $signed({{2{x[W-1]}}, x}) - r;
        if (d > hi)      return hi[W-1:0];
        else if (d < lo) return lo[W-1:0];
        else             return d[W-1:0];
    endfunction

    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_FILL: if (in_valid && (fill == FW'(DEPTH - 1))) st_nxt = ST_RUN;
            ST_RUN:  st_nxt = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_FILL;
        else        st <= st_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                            fill <= '0;
        else if ((st == ST_FILL) && in_valid)  fill <= fill + FW'(1);
    end

    // a symbol boundary at the head takes the decision formed most recently
    always_comb begin
        use_bit = head_st ? dec_bit : act_bit;
        use_amp = head_st ? dec_amp : act_amp;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_i     <= '0;
            out_q     <= '0;
            act_bit   <= 1'b1;
            act_amp   <= '0;
        end else begin
            out_valid <= 1'b0;
            if ((st == ST_RUN) && in_valid) begin
                out_valid <= 1'b1;
                out_i     <= cancel_one(head_i, head_pi, use_bit, use_amp);
                out_q     <= cancel_one(head_q, head_pq, use_bit, use_amp);
                if (head_st) begin
                    act_bit <= dec_bit;
                    act_amp <= dec_amp;
                end
            end
        end
    end

    AST_FILL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FILL) |=> !out_valid); // R4

    AST_OUT_FOLLOWS_IN: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid)); // R8

    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_RUN) && in_valid && !head_st && (act_amp == '0))
        |=> ((out_i == $past(head_i)) && (out_q == $past(head_q)))); // R6

    AST_ADOPT_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_RUN) && in_valid && head_st) |=> (act_amp == $past(dec_amp))); // R5

endmodule

// File: rtl/sic_stage.sv
module sic_stage #(
    parameter int SAMPLE_W = 12,
    parameter int SPS      = 8,
    parameter int SPREAD   = 7
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic signed [SAMPLE_W-1:0] in_i,
    input  logic signed [SAMPLE_W-1:0] in_q,
    input  logic                       pn_i,
    input  logic                       pn_q,
    input  logic                       sym_start,
    output logic                       out_valid,
    output logic signed [SAMPLE_W-1:0] out_i,
    output logic signed [SAMPLE_W-1:0] out_q,
    output logic                       dec_valid,
    output logic                       dec_bit,
    output logic [SAMPLE_W-1:0]        dec_amp
);
    localparam int DEPTH = SPS + SPREAD;

    logic signed [SAMPLE_W-1:0] head_i, head_q;
    logic                       head_pi, head_pq, head_st;

    sic_correlator #(.W(SAMPLE_W), .SPS(SPS)) u_corr (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .x_i       (in_i),
        .x_q       (in_q),
        .pn_i      (pn_i),
        .pn_q      (pn_q),
        .sym_start (sym_start),
        .dec_valid (dec_valid),
        .dec_bit   (dec_bit),
        .dec_amp   (dec_amp)
    );

    sic_delay_line #(.W(SAMPLE_W), .DEPTH(DEPTH)) u_dly (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (in_valid),
        .din_i    (in_i),
        .din_q    (in_q),
        .din_pi   (pn_i),
        .din_pq   (pn_q),
        .din_st   (sym_start),
        .head_i   (head_i),
        .head_q   (head_q),
        .head_pi  (head_pi),
        .head_pq  (head_pq),
        .head_st  (head_st)
    );

    sic_canceller #(.W(SAMPLE_W), .DEPTH(DEPTH)) u_canc (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .head_i    (head_i),
        .head_q    (head_q),
        .head_pi   (head_pi),
        .head_pq   (head_pq),
        .head_st   (head_st),
        .dec_bit   (dec_bit),
        .dec_amp   (dec_amp),
        .out_valid (out_valid),
        .out_i     (out_i),
        .out_q     (out_q)
    );

endmodule

// File: tb/sic_stage_tb_top.sv
module sic_stage_tb_top;
    localparam int W      = 12;
    localparam int SPS    = 8;
    localparam int SPREAD = 7;
    localparam int D      = SPS + SPREAD;
    localparam int L      = 3;
    localparam int NS_MAX = 96;
    localparam int NSYM   = 8;
    localparam int MAXV   = 2047;
    localparam int MINV   = -2048;

    // per symbol: wanted amplitude, wanted bit, interferer amplitude, interferer bit
    localparam int TBL [NSYM][4] = '{
        '{400, 1, 100, 0}, '{400, 0, 100, 1}, '{900, 1, 800, 1}, '{300, 0, 0, 0},
        '{1500, 1, 1500, 0}, '{1200, 0, 300, 1}, '{50, 1, 600, 0}, '{2047, 1, 0, 0}
    };

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n, in_valid, pn_i, pn_q, sym_start;
    logic signed [W-1:0] in_i, in_q;
    logic out_valid, dec_valid, dec_bit;
    logic signed [W-1:0] out_i, out_q;
    logic [W-1:0] dec_amp;

    sic_stage #(.SAMPLE_W(W), .SPS(SPS), .SPREAD(SPREAD)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
        .pn_i(pn_i), .pn_q(pn_q), .sym_start(sym_start), .out_valid(out_valid),
        .out_i(out_i), .out_q(out_q), .dec_valid(dec_valid), .dec_bit(dec_bit),
        .dec_amp(dec_amp)
    );

    int errs = 0, checks = 0;
    int s_i [NS_MAX], s_q [NS_MAX];
    bit s_pi [NS_MAX], s_pq [NS_MAX], s_st [NS_MAX];
    int n_smp;
    int e_oi [NS_MAX], e_oq [NS_MAX], sym_of [NS_MAX];
    string e_tag [NS_MAX];
    int e_db [NS_MAX], e_da [NS_MAX];
    int n_exp_dec, n_r7;
    int got_out, got_dec, acc_cnt;
    bit v_edge;

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int clampw(input int v);
        if (v > MAXV) return MAXV;
        if (v < MINV) return MINV;
        return v;
    endfunction

    function automatic int sgn(input bit b);
        return b ? 1 : -1;
    endfunction

    // independent expectation from the requirements
    task automatic model();
        int acc = 0, cnt = 0, cur = -1, ns = 0;
        bit open = 0;
        n_exp_dec = 0;
        n_r7 = 0;
        for (int j = 0; j < n_smp; j++) begin
            if (s_st[j]) begin open = 1; acc = 0; cnt = 0; cur = ns; ns++; end
            if (open) begin
                acc += sgn(s_pi[j]) * s_i[j] + sgn(s_pq[j]) * s_q[j];
                cnt++;
                if (cnt == SPS) begin
                    e_db[n_exp_dec] = (acc >= 0) ? 1 : 0;
                    e_da[n_exp_dec] = ((acc < 0) ? -acc : acc) >>> (L + 1);
                    n_exp_dec++;
                    open = 0;
                end
            end
            sym_of[j] = cur;
        end
        for (int j = 0; j < n_smp; j++) begin
            int a, vi, vq;
            bit b;
            if (sym_of[j] < 0) begin a = 0; b = 1; end
            else begin a = e_da[sym_of[j]]; b = e_db[sym_of[j]][0]; end
            vi = s_i[j] - ((b == s_pi[j]) ? a : -a);
            vq = s_q[j] - ((b == s_pq[j]) ? a : -a);
            e_oi[j] = clampw(vi);
            e_oq[j] = clampw(vq);
            if (sym_of[j] < 0) e_tag[j] = "R6";
            else if (vi != e_oi[j] || vq != e_oq[j]) begin e_tag[j] = "R7"; n_r7++; end
            else e_tag[j] = "R5";
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; in_valid = 1'b0; in_i = '0; in_q = '0;
        pn_i = 1'b0; pn_q = 1'b0; sym_start = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        got_out = 0; got_dec = 0; acc_cnt = 0;
        rst_n = 1'b1;
    endtask

    task automatic drive(input bit gaps);
        for (int j = 0; j < n_smp; j++) begin
            if (gaps && (j % 5 == 2)) begin
                @(posedge clk); #1;
                in_valid = 1'b0;
            end
            @(posedge clk); #1;
            in_valid = 1'b1;
            in_i = W'(s_i[j]); in_q = W'(s_q[j]);
            pn_i = s_pi[j]; pn_q = s_pq[j]; sym_start = s_st[j];
        end
        @(posedge clk); #1;
        in_valid = 1'b0; sym_start = 1'b0;
        repeat (4) @(posedge clk);
        #1;
        chk(got_out == n_smp - D, "R4", "output count", got_out, n_smp - D);
        chk(got_dec == n_exp_dec, "R2", "decision count", got_dec, n_exp_dec);
    endtask

    task automatic build_table(input int offset);
        n_smp = 0;
        for (int j = 0; j < offset; j++) begin
            s_i[n_smp] = j * 300 - 400; s_q[n_smp] = 250 - j * 170;
            s_pi[n_smp] = j[0]; s_pq[n_smp] = !j[1]; s_st[n_smp] = 0;
            n_smp++;
        end
        for (int k = 0; k < NSYM + 2; k++) begin
            for (int c = 0; c < SPS; c++) begin
                int j, A, d, B, e, nz;
                bit qi, qq;
                j = n_smp;
                A = (k < NSYM) ? TBL[k][0] : 0;
                d = (k < NSYM) ? TBL[k][1] : 1;
                B = (k < NSYM) ? TBL[k][2] : 0;
                e = (k < NSYM) ? TBL[k][3] : 1;
                s_pi[j] = ((((j * 29 + 11) >> 3) ^ (j >> 1)) & 1) != 0;
                s_pq[j] = ((((j * 19 + 5) >> 2) ^ j) & 1) != 0;
                qi = (((j * 11) >> 1) & 1) != 0;
                qq = (((j * 7 + 3) >> 2) & 1) != 0;
                nz = ((j * 37) % 21) - 10;
                s_i[j] = clampw(A * sgn(d[0]) * sgn(s_pi[j]) + B * sgn(e[0]) * sgn(qi) + nz);
                s_q[j] = clampw(A * sgn(d[0]) * sgn(s_pq[j]) + B * sgn(e[0]) * sgn(qq) - nz);
                s_st[j] = (c == 0);
                n_smp++;
            end
        end
    endtask

    task automatic build_sat();
        n_smp = 0;
        for (int k = 0; k < 4; k++) begin
            for (int c = 0; c < SPS; c++) begin
                int j;
                j = n_smp;
                s_st[j] = (c == 0);
                if (k == 0) begin
                    s_i[j] = MAXV; s_q[j] = MAXV; s_pq[j] = 1; s_pi[j] = (c != 3);
                end else if (k == 1) begin
                    s_i[j] = MINV; s_q[j] = MINV; s_pq[j] = 0; s_pi[j] = (c == 5);
                end else begin
                    s_i[j] = 0; s_q[j] = 0; s_pi[j] = c[0]; s_pq[j] = c[1];
                end
                n_smp++;
            end
        end
    endtask

    always @(posedge clk) begin
        v_edge = in_valid && rst_n;
        if (v_edge) acc_cnt++;
    end

    always @(negedge clk) begin
        if (!rst_n) begin
            chk(!out_valid && !dec_valid, "R1", "strobes in reset", int'(out_valid) + int'(dec_valid), 0);
        end else begin
            if (out_valid) begin
                chk(v_edge, "R8", "out_valid without accepted input", 1, 0);
                if (got_out == 0)
                    chk(acc_cnt == D + 1, "R4", "inputs before first output", acc_cnt, D + 1);
                if (got_out < n_smp) begin
                    chk(int'(out_i) == e_oi[got_out], e_tag[got_out], "out_i", int'(out_i), e_oi[got_out]);
                    chk(int'(out_q) == e_oq[got_out], e_tag[got_out], "out_q", int'(out_q), e_oq[got_out]);
                end
                got_out++;
            end
            if (dec_valid) begin
                if (got_dec < n_exp_dec) begin
                    chk(int'(dec_bit) == e_db[got_dec], "R2", "dec_bit", int'(dec_bit), e_db[got_dec]);
                    chk(int'(dec_amp) == e_da[got_dec], "R3", "dec_amp", int'(dec_amp), e_da[got_dec]);
                end
                got_dec++;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        do_reset();
        @(negedge clk);
        chk(!out_valid && !dec_valid, "R1", "strobes after reset", int'(out_valid) + int'(dec_valid), 0);
        chk(out_i == 0 && out_q == 0, "R1", "outputs after reset", int'(out_i), 0);

        // table stream with idle gaps: R2 R3 R5 R6 R8, boundary collision each symbol
        build_table(3);
        model();
        drive(1'b1);

        // same table, other offset, no gaps
        do_reset();
        build_table(5);
        model();
        drive(1'b0);

        // saturation at both rails: R7
        do_reset();
        build_sat();
        model();
        chk(n_r7 >= 2, "R7", "saturating samples in stimulus", n_r7, 2);
        chk(e_oi[3] == MAXV && e_oi[13] == MINV, "R7", "model rails", e_oi[3], MAXV);
        drive(1'b1);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule